// File: doc/BRIEF.md
# Configurable GPIO Bank with Per-Pin Drive Mode

This block implements one general-purpose I/O bank of up to eight pins. Software reaches it through a window of four byte-wide registers on an indexed configuration bus. The window starts at a parameterised base index. Inside the window, one register sets each pin's direction and one holds the value to drive. A third, read-only register returns the synchronised level seen on each pin. The fourth selects, pin by pin, whether an output drives actively in both directions (push-pull) or only pulls low (open-drain).

For each pin the block produces a drive value and an output enable for an external pad cell. The output enable depends on both the direction bit and the drive mode. External pin levels pass through a two-stage synchronizer before software can read them. A parameter narrows the bank to fewer than eight pins. The register bits for the missing pins then read back as zero.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset every register reads 0, so every pin is an input in open-drain mode, and pin_oe is all zero.
- R2: The direction register sits at offset 0 from the bank base; a written 1 makes that pin an output, a 0 an input, and the value reads back the cycle after the write.
- R3: The output-value register sits at offset 1; pin_out follows it, and it keeps its contents while the pin is an input, so a value preloaded there appears on the pin when it is later made an output.
- R4: The pin-level register sits at offset 2 and is read-only; a write to it changes no register and no output.
- R5: The drive-mode register sits at offset 3; bit value 0 selects open-drain and 1 selects push-pull for that pin, and it reads back after a write.
- R6: A pin that is an output in push-pull mode has its output enable asserted whatever its output value.
- R7: A pin that is an output in open-drain mode has its output enable asserted only while its output-value bit is 0; with the bit at 1 the pin is released.
- R8: A change on pin_in shows in the pin-level register after exactly two rising clock edges.
- R9: When the bank implements fewer than eight pins, the register bits above the implemented pins read 0 and ignore writes.
- R10: A write to an index outside the four-register window leaves every register of the bank unchanged, and reads outside the window return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | ADDR_W | Register index on the configuration bus |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data for the indexed register, 0 outside the window |
| pin_in | input | PIN_COUNT | Levels sampled from the external pins |
| pin_out | output | PIN_COUNT | Value driven to the pad cells |
| pin_oe | output | PIN_COUNT | Output enable to the pad cells |

## Verification
The assertions check several behaviours on every cycle. Each write lands in the register its offset names. Writes to the read-only offset and to foreign indices disturb nothing. Push-pull outputs are always enabled, and open-drain outputs holding a 1 are never enabled. Only the bench's scenarios can show the rest: the synchronizer latency counted edge by edge, a value preloaded while the pin is an input appearing once the pin turns to output, the reset values, and the masking of missing pins in a five-pin instance.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    // Offsets inside the four-register window; the order is fixed by software.
    typedef enum logic [1:0] {
        OFS_DIR  = 2'd0,
        OFS_VAL  = 2'd1,
        OFS_LVL  = 2'd2,
        OFS_MODE = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                PIN_COUNT = 8,
    parameter logic [ADDR_W-1:0] BANK_BASE = 'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [PIN_COUNT-1:0] lvl_sync,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic [PIN_COUNT-1:0] dir_o,
    output logic [PIN_COUNT-1:0] val_o,
    output logic [PIN_COUNT-1:0] mode_o
);
    localparam logic [ADDR_W-3:0] BASE_TAG = BANK_BASE[ADDR_W-1:2];

    typedef struct packed {
        logic [PIN_COUNT-1:0] dir;
        logic [PIN_COUNT-1:0] val;
        logic [PIN_COUNT-1:0] mode;
    } bank_t;

    bank_t    bk_d, bk_q;
    logic     hit;
    reg_ofs_e ofs;
    logic [PIN_COUNT-1:0] wbits;

    assign hit   = (cfg_addr[ADDR_W-1:2] == BASE_TAG);
    assign ofs   = reg_ofs_e'(cfg_addr[1:0]);
    assign wbits = cfg_wdata[PIN_COUNT-1:0];

    always_comb begin
        bk_d = bk_q;
        if (cfg_wr && hit) begin
            case (ofs)
                OFS_DIR:  bk_d.dir  = wbits;
                OFS_VAL:  bk_d.val  = wbits;
                OFS_MODE: bk_d.mode = wbits;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            case (ofs)
                OFS_DIR:  cfg_rdata = DATA_W'(bk_q.dir);
                OFS_VAL:  cfg_rdata = DATA_W'(bk_q.val);
                OFS_LVL:  cfg_rdata = DATA_W'(lvl_sync);
                OFS_MODE: cfg_rdata = DATA_W'(bk_q.mode);
                default:  cfg_rdata = '0;
            endcase
        end
    end

    assign dir_o  = bk_q.dir;
    assign val_o  = bk_q.val;
    assign mode_o = bk_q.mode;

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == BANK_BASE) |=> (dir_o == $past(cfg_wdata[PIN_COUNT-1:0])));
    a_r3_val_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == BANK_BASE + 1) |=> (val_o == $past(cfg_wdata[PIN_COUNT-1:0])));
    a_r5_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == BANK_BASE + 3) |=> (mode_o == $past(cfg_wdata[PIN_COUNT-1:0])));
    a_r4_level_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == BANK_BASE + 2) |=> ($stable(dir_o) && $stable(val_o) && $stable(mode_o)));
    a_r10_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_addr < BANK_BASE || cfg_addr > BANK_BASE + 3))
        |=> ($stable(dir_o) && $stable(val_o) && $stable(mode_o)));
endmodule

// File: rtl/gpb_drive.sv
module gpb_drive #(
    parameter int PIN_COUNT = 8
) (
    input  logic [PIN_COUNT-1:0] dir,
    input  logic [PIN_COUNT-1:0] val,
    input  logic [PIN_COUNT-1:0] mode,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        // Open-drain pins drive only a low level; push-pull pins drive both.
        assign pin_out[i] = val[i];
        assign pin_oe[i]  = dir[i] & (mode[i] | ~val[i]);
    end
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                PIN_COUNT = 8,
    parameter logic [ADDR_W-1:0] BANK_BASE = 'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    logic [PIN_COUNT-1:0] lvl_sync, dir_q, val_q, mode_q;

    gpb_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_sync)
    );

    gpb_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT), .BANK_BASE(BANK_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .lvl_sync(lvl_sync), .cfg_rdata(cfg_rdata),
        .dir_o(dir_q), .val_o(val_q), .mode_o(mode_q)
    );

    gpb_drive #(.PIN_COUNT(PIN_COUNT)) u_drive (
        .dir(dir_q), .val(val_q), .mode(mode_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    a_r6_push_pull_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & dir_q & mode_q) == (dir_q & mode_q)));
    a_r7_open_drain_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~mode_q & val_q) == '0));
    a_r1_inputs_float: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~dir_q) == '0));
endmodule

// File: tb/sim_gpio_bank_ctl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] rdata0, rdata1;
    logic [7:0] pin_in = '0;
    logic [7:0] pout0, poe0;
    logic [4:0] pout1, poe1;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    gpio_bank_ctl #(.PIN_COUNT(8), .BANK_BASE(8'hF0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata0), .pin_in(pin_in),
        .pin_out(pout0), .pin_oe(poe0)
    );

    gpio_bank_ctl #(.PIN_COUNT(5), .BANK_BASE(8'hE0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata1), .pin_in(pin_in[4:0]),
        .pin_out(pout1), .pin_oe(poe1)
    );

    // Scoreboard queues: expected read data, which instance, requirement tag.
    int    exp_q[$];
    bit    sel_q[$];
    string tag_q[$];
    logic  rd_act = 1'b0;

    always @(negedge clk) begin
        if (rd_act && exp_q.size() > 0) begin
            int    e;
            bit    s;
            string t;
            logic [7:0] got;
            e = exp_q.pop_front();
            s = sel_q.pop_front();
            t = tag_q.pop_front();
            got = s ? rdata1 : rdata0;
            total++;
            if (got !== 8'(e)) begin
                bad++;
                $display("FAIL %s: read got 0x%02h expected 0x%02h", t, got, 8'(e));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input bit s, input logic [7:0] a, input int e, input string t);
        @(posedge clk); #1;
        cfg_addr = a;
        exp_q.push_back(e); sel_q.push_back(s); tag_q.push_back(t);
        rd_act = 1'b1;
        @(negedge clk); #1;
        rd_act = 1'b0;
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] e, input string t);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", t, got, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd(0, 8'hF0, 0, "R1 dir");
        rd(0, 8'hF1, 0, "R1 val");
        rd(0, 8'hF3, 0, "R1 mode");
        rd(1, 8'hE0, 0, "R1 dir u1");
        chk(poe0, 8'h00, "R1 pin_oe");

        // R2 + R7: outputs in open-drain with value 0 are driven
        wr(8'hF0, 8'hA5);
        rd(0, 8'hF0, 8'hA5, "R2 dir readback");
        chk(poe0, 8'hA5, "R7 open-drain low driven");

        // R7 release with value 1, R3 pin_out follows
        wr(8'hF1, 8'hFF);
        chk(poe0, 8'h00, "R7 open-drain high released");
        chk(pout0, 8'hFF, "R3 pin_out");

        // R5 + R6 push-pull on low nibble
        wr(8'hF3, 8'h0F);
        rd(0, 8'hF3, 8'h0F, "R5 mode readback");
        chk(poe0, 8'h05, "R6 push-pull enabled");

        // R3 preload while input
        wr(8'hF0, 8'h00);
        wr(8'hF1, 8'h3C);
        chk(poe0, 8'h00, "R3 inputs not driven");
        rd(0, 8'hF1, 8'h3C, "R3 preload retained");
        wr(8'hF3, 8'hFF);
        wr(8'hF0, 8'hFF);
        chk(pout0, 8'h3C, "R3 preload on pin");
        chk(poe0, 8'hFF, "R6 all push-pull outputs");

        // R8: two-edge synchronizer latency
        @(posedge clk); #1;
        pin_in = 8'h96;
        rd(0, 8'hF2, 8'h00, "R8 one edge");
        rd(0, 8'hF2, 8'h96, "R8 two edges");

        // R4: write to read-only offset is ignored
        wr(8'hF2, 8'h00);
        rd(0, 8'hF2, 8'h96, "R4 level kept");
        rd(0, 8'hF0, 8'hFF, "R4 dir unchanged");
        chk(pout0, 8'h3C, "R4 pin_out unchanged");

        // R10: writes outside the window
        wr(8'hF4, 8'h00);
        wr(8'hEF, 8'h00);
        rd(0, 8'hF0, 8'hFF, "R10 dir unchanged");
        rd(0, 8'hF1, 8'h3C, "R10 val unchanged");
        rd(0, 8'hF7, 8'h00, "R10 outside read zero");

        // R9: five-pin bank masks upper bits
        wr(8'hE0, 8'hFF);
        rd(1, 8'hE0, 8'h1F, "R9 dir masked");
        wr(8'hE1, 8'hE0);
        rd(1, 8'hE1, 8'h00, "R9 val upper ignored");
        rd(1, 8'hE2, 8'h16, "R9 level masked");
        chk({3'b000, poe1}, 8'h1F, "R9 open-drain low driven");

        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule